// File: doc/BRIEF.md
# Data-Side Translation Fault Checker

This block sits between the load/store unit, the data TLB and the page table walker and turns each lookup into a translation response. When translation is enabled and the request carries no misalignment exception, it builds the physical page number from the TLB entry. For superpages, the low page-number fields are taken from the virtual address. It returns that page number and a hit flag in the same cycle. One cycle later it presents the complete physical address together with any exception.

The permission logic decides between page faults and access faults. Page faults come from the PTE bits and the privilege state. Access faults come from an externally computed physical-protection allow signal. A page fault always wins over an access fault. On a TLB miss, errors reported by the walker are turned into exceptions. With translation off, the virtual address is passed straight through and only the protection result can fault the request. The exception carries a standard cause code and the faulting virtual address.

Top module: `dxl_xlate_resp`

## Requirements
- R1: After reset, and while reset is asserted, `valid_o` and `exc_valid_o` are 0.
- R2: `hit_o` is 1 in the same cycle exactly when a request is valid, translation is enabled, no misalignment is flagged and the TLB hits. In that cycle `ppn_o` carries the TLB page number.
- R3: One cycle after a translated hit, `valid_o` is 1 and `paddr_o` equals `ppn_o` of the hit cycle concatenated with the 12-bit page offset of the virtual address.
- R4: Leaf level 1 (2 MiB) replaces PPN bits [8:0] with VA bits [20:12]. Leaf level 2 (1 GiB) replaces PPN bits [17:0] with VA bits [29:12]. Both `ppn_o` and `paddr_o` show the replacement. Level 0 is a 4 KiB page.
- R5: A translated request that misses the TLB with no walker error gives `valid_o` = 0 and no exception in the following cycle.
- R6: A store that hits raises a store page fault (cause 15) in any of these cases: the page is not writable, the dirty bit is clear, or the privilege check fails. `exc_tval_o` holds the virtual address.
- R7: A load that hits raises a load page fault (cause 13) in any of these cases:
  - user mode with the U bit clear;
  - supervisor mode with U set and SUM clear;
  - R clear, unless X and MXR are both set.
- R8: On a hit with no page fault, a protection denial raises a load access fault (cause 5) or a store access fault (cause 7). When both kinds of fault apply, the page fault is reported.
- R9: On a miss, a walker page error raises cause 13 for a load or 15 for a store. A walker access error raises cause 5 for either type. If both errors are present, the page error is reported.
- R10: With translation disabled, a valid aligned request gives `valid_o` = 1 one cycle later, with `paddr_o` equal to the zero-extended virtual address. It faults (cause 5 or 7 by type) only when protection denies the access.
- R11: A request flagged as misaligned gives no hit, no `valid_o` and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request present |
| req_store_i | input | 1 | Request is a store (0 = load) |
| req_misalign_i | input | 1 | Load/store unit already flagged a misalignment |
| req_vaddr_i | input | VLEN | Virtual address |
| xlat_en_i | input | 1 | Address translation enabled for data |
| user_mode_i | input | 1 | Effective data privilege is user (0 = supervisor) |
| sum_i | input | 1 | Supervisor may access user pages |
| mxr_i | input | 1 | Executable pages are readable |
| tlb_hit_i | input | 1 | Data TLB hit |
| tlb_ppn_i | input | PPNW | Page number from the TLB entry |
| tlb_leaf_lvl_i | input | LVLW | Leaf level of the entry: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| pte_r_i | input | 1 | Entry readable |
| pte_w_i | input | 1 | Entry writable |
| pte_x_i | input | 1 | Entry executable |
| pte_u_i | input | 1 | Entry is a user page |
| pte_d_i | input | 1 | Entry dirty |
| pmp_allow_i | input | 1 | Physical protection permits this access |
| walk_page_err_i | input | 1 | Walker found a page fault for this request |
| walk_acc_err_i | input | 1 | Walker hit an access error for this request |
| hit_o | output | 1 | Same-cycle hit |
| ppn_o | output | PPNW | Same-cycle page number after superpage correction |
| valid_o | output | 1 | Registered response valid |
| paddr_o | output | PLEN | Registered physical address |
| exc_valid_o | output | 1 | Registered exception valid |
| exc_cause_o | output | XLEN | Exception cause code |
| exc_tval_o | output | XLEN | Faulting virtual address |

## Verification
The hardest case to reach is a request where several fault sources are true at once. Examples are a store that is both non-writable and denied by protection, or a miss where the walker reports a page error and an access error together. Only there does the priority order become visible. The directed tasks hold one request steady and set these conflicting inputs in the same cycle. They then read the cause one edge later, alongside single-source cases for each privilege rule and each leaf level.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

  localparam int PG_OFFS_W = 12;
  localparam int VPN_FLD_W = 9;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_LD_PF = 3'd1,
    FLT_ST_PF = 3'd2,
    FLT_LD_AF = 3'd3,
    FLT_ST_AF = 3'd4
  } fault_e;

  function automatic logic [3:0] cause_code(input fault_e f);
    case (f)
      FLT_LD_PF: cause_code = 4'd13;
      FLT_ST_PF: cause_code = 4'd15;
      FLT_LD_AF: cause_code = 4'd5;
      FLT_ST_AF: cause_code = 4'd7;
      default:   cause_code = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/dxl_addr_form.sv
module dxl_addr_form
  import dxl_pkg::*;
#(
  parameter int PPNW      = 44,
  parameter int PT_LEVELS = 3,
  parameter int LVLW      = 2,
  localparam int SP_W     = (PT_LEVELS - 1) * VPN_FLD_W
) (
  input  logic [PPNW-1:0] ppn_i,
  input  logic [SP_W-1:0] vpn_lo_i,
  input  logic [LVLW-1:0] leaf_lvl_i,
  output logic [PPNW-1:0] ppn_o
);

  assign ppn_o[PPNW-1:SP_W] = ppn_i[PPNW-1:SP_W];

  for (genvar k = 0; k < PT_LEVELS - 1; k++) begin : g_fld
    logic take_va;
    assign take_va = (int'(leaf_lvl_i) > k);
    assign ppn_o[k*VPN_FLD_W +: VPN_FLD_W] = take_va ? vpn_lo_i[k*VPN_FLD_W +: VPN_FLD_W]
                                                     : ppn_i[k*VPN_FLD_W +: VPN_FLD_W];
  end

endmodule

// File: rtl/dxl_fault_eval.sv
module dxl_fault_eval
  import dxl_pkg::*;
(
  input  logic   xlat_req_i,
  input  logic   bypass_req_i,
  input  logic   tlb_hit_i,
  input  logic   is_store_i,
  input  logic   user_mode_i,
  input  logic   sum_i,
  input  logic   mxr_i,
  input  logic   pte_r_i,
  input  logic   pte_w_i,
  input  logic   pte_x_i,
  input  logic   pte_u_i,
  input  logic   pte_d_i,
  input  logic   pmp_allow_i,
  input  logic   walk_page_err_i,
  input  logic   walk_acc_err_i,
  output logic   resp_valid_o,
  output fault_e fault_o
);

  logic priv_bad;
  logic ld_pf;
  logic st_pf;
  logic walk_err;

  always_comb begin
    priv_bad = user_mode_i ? !pte_u_i : (pte_u_i && !sum_i);
    ld_pf    = priv_bad || !(pte_r_i || (pte_x_i && mxr_i));
    st_pf    = priv_bad || !pte_w_i || !pte_d_i;
    walk_err = walk_page_err_i || walk_acc_err_i;
  end

  always_comb begin
    resp_valid_o = 1'b0;
    fault_o      = FLT_NONE;
    if (xlat_req_i && tlb_hit_i) begin
      resp_valid_o = 1'b1;
      if (is_store_i) begin
        if (st_pf)             fault_o = FLT_ST_PF;
        else if (!pmp_allow_i) fault_o = FLT_ST_AF;
      end else begin
        if (ld_pf)             fault_o = FLT_LD_PF;
        else if (!pmp_allow_i) fault_o = FLT_LD_AF;
      end
    end else if (xlat_req_i && walk_err) begin
      resp_valid_o = 1'b1;
      if (walk_page_err_i) fault_o = is_store_i ? FLT_ST_PF : FLT_LD_PF;
      else                 fault_o = FLT_LD_AF;
    end else if (bypass_req_i) begin
      resp_valid_o = 1'b1;
      if (!pmp_allow_i) fault_o = is_store_i ? FLT_ST_AF : FLT_LD_AF;
    end
  end

endmodule

// File: rtl/dxl_resp_reg.sv
module dxl_resp_reg
  import dxl_pkg::*;
#(
  parameter int PLEN = 56,
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            resp_valid_i,
  input  fault_e          fault_i,
  input  logic [PLEN-1:0] paddr_i,
  input  logic [XLEN-1:0] tval_i,
  output logic            valid_o,
  output logic [PLEN-1:0] paddr_o,
  output logic            exc_valid_o,
  output logic [XLEN-1:0] exc_cause_o,
  output logic [XLEN-1:0] exc_tval_o
);

  logic            valid_q, valid_n;
  fault_e          fault_q, fault_n;
  logic [PLEN-1:0] paddr_q, paddr_n;
  logic [XLEN-1:0] tval_q, tval_n;
  logic            data_en;

  always_comb begin
    data_en = resp_valid_i;
    valid_n = resp_valid_i;
    fault_n = resp_valid_i ? fault_i : FLT_NONE;
    paddr_n = data_en ? paddr_i : paddr_q;
    tval_n  = data_en ? tval_i : tval_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fault_q <= FLT_NONE;
    end else begin
      valid_q <= valid_n;
      fault_q <= fault_n;
    end
  end

  always_ff @(posedge clk_i) begin
    paddr_q <= paddr_n;
    tval_q  <= tval_n;
  end

  assign valid_o     = valid_q;
  assign paddr_o     = paddr_q;
  assign exc_valid_o = valid_q && (fault_q != FLT_NONE);
  assign exc_cause_o = XLEN'(cause_code(fault_q));
  assign exc_tval_o  = tval_q;

endmodule

// File: rtl/dxl_xlate_resp.sv
module dxl_xlate_resp
  import dxl_pkg::*;
#(
  parameter int VLEN      = 39,
  parameter int PPNW      = 44,
  parameter int PT_LEVELS = 3,
  parameter int XLEN      = 64,
  localparam int PLEN     = PPNW + PG_OFFS_W,
  localparam int LVLW     = $clog2(PT_LEVELS),
  localparam int SP_W     = (PT_LEVELS - 1) * VPN_FLD_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_store_i,
  input  logic            req_misalign_i,
  input  logic [VLEN-1:0] req_vaddr_i,
  input  logic            xlat_en_i,
  input  logic            user_mode_i,
  input  logic            sum_i,
  input  logic            mxr_i,
  input  logic            tlb_hit_i,
  input  logic [PPNW-1:0] tlb_ppn_i,
  input  logic [LVLW-1:0] tlb_leaf_lvl_i,
  input  logic            pte_r_i,
  input  logic            pte_w_i,
  input  logic            pte_x_i,
  input  logic            pte_u_i,
  input  logic            pte_d_i,
  input  logic            pmp_allow_i,
  input  logic            walk_page_err_i,
  input  logic            walk_acc_err_i,
  output logic            hit_o,
  output logic [PPNW-1:0] ppn_o,
  output logic            valid_o,
  output logic [PLEN-1:0] paddr_o,
  output logic            exc_valid_o,
  output logic [XLEN-1:0] exc_cause_o,
  output logic [XLEN-1:0] exc_tval_o
);

  logic            xlat_req;
  logic            bypass_req;
  logic [PPNW-1:0] ppn_fix;
  logic [PLEN-1:0] paddr_d;
  logic [XLEN-1:0] tval_d;
  logic            resp_valid;
  fault_e          fault_d;

  always_comb begin
    xlat_req   = req_valid_i && xlat_en_i && !req_misalign_i;
    bypass_req = req_valid_i && !xlat_en_i && !req_misalign_i;
  end

  dxl_addr_form #(
    .PPNW      (PPNW),
    .PT_LEVELS (PT_LEVELS),
    .LVLW      (LVLW)
  ) u_form (
    .ppn_i      (tlb_ppn_i),
    .vpn_lo_i   (req_vaddr_i[PG_OFFS_W +: SP_W]),
    .leaf_lvl_i (tlb_leaf_lvl_i),
    .ppn_o      (ppn_fix)
  );

  dxl_fault_eval u_eval (
    .xlat_req_i      (xlat_req),
    .bypass_req_i    (bypass_req),
    .tlb_hit_i       (tlb_hit_i),
    .is_store_i      (req_store_i),
    .user_mode_i     (user_mode_i),
    .sum_i           (sum_i),
    .mxr_i           (mxr_i),
    .pte_r_i         (pte_r_i),
    .pte_w_i         (pte_w_i),
    .pte_x_i         (pte_x_i),
    .pte_u_i         (pte_u_i),
    .pte_d_i         (pte_d_i),
    .pmp_allow_i     (pmp_allow_i),
    .walk_page_err_i (walk_page_err_i),
    .walk_acc_err_i  (walk_acc_err_i),
    .resp_valid_o    (resp_valid),
    .fault_o         (fault_d)
  );

  always_comb begin
    hit_o   = xlat_req && tlb_hit_i;
    ppn_o   = ppn_fix;
    paddr_d = xlat_en_i ? {ppn_fix, req_vaddr_i[PG_OFFS_W-1:0]} : PLEN'(req_vaddr_i);
    tval_d  = XLEN'(req_vaddr_i);
  end

  dxl_resp_reg #(
    .PLEN (PLEN),
    .XLEN (XLEN)
  ) u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .resp_valid_i (resp_valid),
    .fault_i      (fault_d),
    .paddr_i      (paddr_d),
    .tval_i       (tval_d),
    .valid_o      (valid_o),
    .paddr_o      (paddr_o),
    .exc_valid_o  (exc_valid_o),
    .exc_cause_o  (exc_cause_o),
    .exc_tval_o   (exc_tval_o)
  );

endmodule

// File: rtl/dxl_xlate_resp_chk.sv
module dxl_xlate_resp_chk #(
  parameter int VLEN      = 39,
  parameter int PPNW      = 44,
  parameter int PT_LEVELS = 3,
  parameter int XLEN      = 64,
  parameter int PLEN      = 56,
  parameter int LVLW      = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_store_i,
  input logic            req_misalign_i,
  input logic [VLEN-1:0] req_vaddr_i,
  input logic            xlat_en_i,
  input logic            tlb_hit_i,
  input logic [LVLW-1:0] tlb_leaf_lvl_i,
  input logic            pte_w_i,
  input logic            pmp_allow_i,
  input logic            walk_page_err_i,
  input logic            walk_acc_err_i,
  input logic            hit_o,
  input logic [PPNW-1:0] ppn_o,
  input logic            valid_o,
  input logic [PLEN-1:0] paddr_o,
  input logic            exc_valid_o,
  input logic [XLEN-1:0] exc_cause_o
);

  localparam int SP_W = (PT_LEVELS - 1) * 9;

  p_exc_needs_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> valid_o);

  p_offset_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_misalign_i && (tlb_hit_i || !xlat_en_i))
    |=> (valid_o && paddr_o[11:0] == $past(req_vaddr_i[11:0])));

  p_top_leaf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && int'(tlb_leaf_lvl_i) == PT_LEVELS - 1) |-> (ppn_o[SP_W-1:0] == req_vaddr_i[12 +: SP_W]));

  p_page_over_access_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && req_store_i && !pte_w_i && !pmp_allow_i) |=> (exc_valid_o && exc_cause_o == XLEN'(15)));

  p_walk_access_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && xlat_en_i && !req_misalign_i && !tlb_hit_i && walk_acc_err_i && !walk_page_err_i)
    |=> (exc_valid_o && exc_cause_o == XLEN'(5)));

  p_bypass_answers_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !xlat_en_i && !req_misalign_i) |=> valid_o);

  p_misalign_silent_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_misalign_i) |=> (!valid_o && !exc_valid_o));

  p_misalign_nohit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_misalign_i |-> !hit_o);

endmodule

bind dxl_xlate_resp dxl_xlate_resp_chk #(
  .VLEN      (VLEN),
  .PPNW      (PPNW),
  .PT_LEVELS (PT_LEVELS),
  .XLEN      (XLEN),
  .PLEN      (PLEN),
  .LVLW      (LVLW)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_store_i     (req_store_i),
  .req_misalign_i  (req_misalign_i),
  .req_vaddr_i     (req_vaddr_i),
  .xlat_en_i       (xlat_en_i),
  .tlb_hit_i       (tlb_hit_i),
  .tlb_leaf_lvl_i  (tlb_leaf_lvl_i),
  .pte_w_i         (pte_w_i),
  .pmp_allow_i     (pmp_allow_i),
  .walk_page_err_i (walk_page_err_i),
  .walk_acc_err_i  (walk_acc_err_i),
  .hit_o           (hit_o),
  .ppn_o           (ppn_o),
  .valid_o         (valid_o),
  .paddr_o         (paddr_o),
  .exc_valid_o     (exc_valid_o),
  .exc_cause_o     (exc_cause_o)
);

// File: tb/dxl_xlate_resp_test.sv
`timescale 1ns/1ps
module dxl_xlate_resp_test;

  localparam int VLEN = 39;
  localparam int PPNW = 44;
  localparam int XLEN = 64;
  localparam int PLEN = PPNW + 12;
  localparam int LVLW = 2;
  localparam real HALF = 2.0;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic req_valid_i, req_store_i, req_misalign_i, xlat_en_i;
  logic [VLEN-1:0] req_vaddr_i;
  logic user_mode_i, sum_i, mxr_i, tlb_hit_i;
  logic [PPNW-1:0] tlb_ppn_i;
  logic [LVLW-1:0] tlb_leaf_lvl_i;
  logic pte_r_i, pte_w_i, pte_x_i, pte_u_i, pte_d_i;
  logic pmp_allow_i, walk_page_err_i, walk_acc_err_i;
  logic hit_o, valid_o, exc_valid_o;
  logic [PPNW-1:0] ppn_o;
  logic [PLEN-1:0] paddr_o;
  logic [XLEN-1:0] exc_cause_o, exc_tval_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [PPNW-1:0] PPN_A = 44'h0AB_CDEF_1234;
  localparam logic [VLEN-1:0] VA_A  = 39'h12_3456_789A;

  always #(HALF) clk_i = ~clk_i;

  dxl_xlate_resp uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid_i = 0; req_store_i = 0; req_misalign_i = 0; xlat_en_i = 0;
    tlb_hit_i = 0; walk_page_err_i = 0; walk_acc_err_i = 0; pmp_allow_i = 1;
  endtask

  task automatic set_pte(input logic r, w, x, u, d);
    pte_r_i = r; pte_w_i = w; pte_x_i = x; pte_u_i = u; pte_d_i = d;
  endtask

  task automatic set_req(input logic st, input logic xl, input logic hit, input logic [LVLW-1:0] lvl);
    req_valid_i = 1; req_store_i = st; xlat_en_i = xl; tlb_hit_i = hit;
    tlb_leaf_lvl_i = lvl; req_vaddr_i = VA_A; tlb_ppn_i = PPN_A;
  endtask

  // Called right after a negedge with inputs driven; checks both timing points.
  task automatic expect_cycle(input string tag, input logic e_hit, input logic [PPNW-1:0] e_ppn,
                              input logic e_valid, input logic e_exc, input logic [XLEN-1:0] e_cause,
                              input logic chk_pa, input logic [PLEN-1:0] e_pa);
    #0.5;
    chk({tag, " hit"}, 64'(hit_o), 64'(e_hit));
    if (e_hit) chk({tag, " ppn"}, 64'(ppn_o), 64'(e_ppn));
    @(negedge clk_i);
    chk({tag, " valid"}, 64'(valid_o), 64'(e_valid));
    chk({tag, " exc"}, 64'(exc_valid_o), 64'(e_exc));
    if (e_exc) begin
      chk({tag, " cause"}, exc_cause_o, e_cause);
      chk({tag, " tval"}, exc_tval_o, 64'(VA_A));
    end
    if (chk_pa) chk({tag, " paddr"}, 64'(paddr_o), 64'(e_pa));
    idle();
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", 64'(valid_o), 64'd0);
    chk("R1 exc in reset", 64'(exc_valid_o), 64'd0);
  endtask

  task automatic t_basic_hit();
    set_pte(1, 1, 0, 0, 1); user_mode_i = 0;
    set_req(0, 1, 1, 0);
    expect_cycle("R2 R3 load 4K", 1, PPN_A, 1, 0, 0, 1, {PPN_A, VA_A[11:0]});
    set_req(1, 1, 1, 0);
    expect_cycle("R2 R3 store 4K", 1, PPN_A, 1, 0, 0, 1, {PPN_A, VA_A[11:0]});
  endtask

  task automatic t_superpage();
    logic [PPNW-1:0] mp, gp;
    mp = {PPN_A[PPNW-1:9], VA_A[20:12]};
    gp = {PPN_A[PPNW-1:18], VA_A[29:12]};
    set_pte(1, 1, 0, 0, 1); user_mode_i = 0;
    set_req(0, 1, 1, 1);
    expect_cycle("R4 2M", 1, mp, 1, 0, 0, 1, {mp, VA_A[11:0]});
    set_req(0, 1, 1, 2);
    expect_cycle("R4 1G", 1, gp, 1, 0, 0, 1, {gp, VA_A[11:0]});
  endtask

  task automatic t_miss();
    set_req(0, 1, 0, 0);
    expect_cycle("R5 miss", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_store_pf();
    user_mode_i = 0; sum_i = 0;
    set_pte(1, 0, 0, 0, 1); set_req(1, 1, 1, 0);
    expect_cycle("R6 not writable", 1, PPN_A, 1, 1, 15, 0, 0);
    set_pte(1, 1, 0, 0, 0); set_req(1, 1, 1, 0);
    expect_cycle("R6 not dirty", 1, PPN_A, 1, 1, 15, 0, 0);
    user_mode_i = 1; set_pte(1, 1, 0, 0, 1); set_req(1, 1, 1, 0);
    expect_cycle("R6 user on super page", 1, PPN_A, 1, 1, 15, 0, 0);
    user_mode_i = 0;
  endtask

  task automatic t_load_pf();
    sum_i = 0; mxr_i = 0;
    user_mode_i = 1; set_pte(1, 0, 0, 0, 0); set_req(0, 1, 1, 0);
    expect_cycle("R7 user U clear", 1, PPN_A, 1, 1, 13, 0, 0);
    user_mode_i = 0; set_pte(1, 0, 0, 1, 0); set_req(0, 1, 1, 0);
    expect_cycle("R7 super U no SUM", 1, PPN_A, 1, 1, 13, 0, 0);
    sum_i = 1; set_req(0, 1, 1, 0);
    expect_cycle("R7 super U with SUM", 1, PPN_A, 1, 0, 0, 0, 0);
    sum_i = 0; set_pte(0, 0, 1, 0, 0); mxr_i = 1; set_req(0, 1, 1, 0);
    expect_cycle("R7 X with MXR", 1, PPN_A, 1, 0, 0, 0, 0);
    mxr_i = 0; set_req(0, 1, 1, 0);
    expect_cycle("R7 X without MXR", 1, PPN_A, 1, 1, 13, 0, 0);
  endtask

  task automatic t_access();
    user_mode_i = 0; set_pte(1, 1, 0, 0, 1);
    set_req(0, 1, 1, 0); pmp_allow_i = 0;
    expect_cycle("R8 load deny", 1, PPN_A, 1, 1, 5, 0, 0);
    set_req(1, 1, 1, 0); pmp_allow_i = 0;
    expect_cycle("R8 store deny", 1, PPN_A, 1, 1, 7, 0, 0);
    set_pte(1, 0, 0, 0, 1); set_req(1, 1, 1, 0); pmp_allow_i = 0;
    expect_cycle("R8 page over access", 1, PPN_A, 1, 1, 15, 0, 0);
  endtask

  task automatic t_walker();
    set_req(1, 1, 0, 0); walk_page_err_i = 1;
    expect_cycle("R9 walk page store", 0, 0, 1, 1, 15, 0, 0);
    set_req(1, 1, 0, 0); walk_acc_err_i = 1;
    expect_cycle("R9 walk access store", 0, 0, 1, 1, 5, 0, 0);
    set_req(0, 1, 0, 0); walk_page_err_i = 1; walk_acc_err_i = 1;
    expect_cycle("R9 walk both load", 0, 0, 1, 1, 13, 0, 0);
  endtask

  task automatic t_bypass();
    set_req(0, 0, 0, 0);
    expect_cycle("R10 pass load", 0, 0, 1, 0, 0, 1, PLEN'(VA_A));
    set_req(1, 0, 1, 0); pmp_allow_i = 0;
    expect_cycle("R10 store deny", 0, 0, 1, 1, 7, 1, PLEN'(VA_A));
    set_req(0, 0, 0, 0); pmp_allow_i = 0;
    expect_cycle("R10 load deny", 0, 0, 1, 1, 5, 0, 0);
  endtask

  task automatic t_misalign();
    set_pte(0, 0, 0, 0, 0);
    set_req(1, 1, 1, 0); req_misalign_i = 1; pmp_allow_i = 0;
    expect_cycle("R11 translated", 0, 0, 0, 0, 0, 0, 0);
    set_req(1, 0, 0, 0); req_misalign_i = 1; pmp_allow_i = 0;
    expect_cycle("R11 bypass", 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_ni = 0; user_mode_i = 0; sum_i = 0; mxr_i = 0;
    req_vaddr_i = '0; tlb_ppn_i = '0; tlb_leaf_lvl_i = '0;
    set_pte(0, 0, 0, 0, 0);
    repeat (2) @(negedge clk_i);
    req_valid_i = 1;
    @(negedge clk_i);
    t_reset();
    idle();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_basic_hit();
    t_superpage();
    t_miss();
    t_store_pf();
    t_load_pf();
    t_access();
    t_walker();
    t_bypass();
    t_misalign();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule